// File: doc/BRIEF.md
# Peripheral Write Protection Controller

This block keeps a write-protect flag and a lock flag for each of 46 protectable peripherals. Software changes the protection by writing a single command word made of an 8-bit key and a 16-bit peripheral identifier. The key selects one of four actions: do nothing, unprotect, protect, or protect and lock. A locked peripheral stays protected until hardware reset, and later protect or unprotect commands aimed at it are refused.

Peripheral identifiers are translated into protect-bit positions in three status groups. Two identifiers share one bit. Several known identifiers have no bit at all and are accepted silently. Refused or malformed commands leave all state untouched and raise a sticky error flag, which software clears by writing a one. On the bus-facing side, a write attempt aimed at a protected peripheral produces a one-cycle access-error pulse.

All registers sit behind a small word-addressed register port whose read data is registered. The protect bits are also driven out as a parallel vector.

Top module: `wprot_ctrl`

## Requirements
- R1: The command register is at word address 0. A write stores the key in bits 23:16 and the identifier in bits 15:0. A read returns those 24 bits with bits 31:24 as zero, and the register reads as zero after reset. Read data appears on the clock edge that samples `cfg_re`.
- R2: The key selects the action. Key 0 leaves the protect bit unchanged, key 1 clears it and key 2 sets it. The change becomes visible on the second rising edge after the write is sampled, and not earlier.
- R3: Key 3 sets the protect bit and the lock bit. Afterwards a key 1 or key 2 command aimed at that bit is refused and the bit stays set. A repeated key 3 or a key 0 on it is not an error. Only reset clears a lock.
- R4: Identifiers map to protect-bit indices as follows:
  - 0 → 0
  - 1..15 → (id-1), with 1 and 2 both giving 1
  - 20..22 → 15..17
  - 25..35 → 18..28
  - 36..50 → 29..43
  - 54 → 44
  - 57 → 45
- R5: Identifiers 1 and 2 control the same protect bit, so a set through one and a clear through the other act on that single bit.
- R6: Identifiers 18, 19, 23, 24, 51, 52, 53, 55 and 56 are known but have no bit. Any key from 0 to 3 on them changes nothing and raises no error.
- R7: The error flag `err_o` is set, and no protect or lock bit changes, for any of these commands:
  - a key above 3
  - an identifier that is not known (16, 17, or above 57)
  - key 1 or key 2 aimed at a locked bit
- R8: The error flag holds until bit 0 is written as 1 at word address 1. Writing 0 there leaves it set. Word 1 reads back the flag in bit 0.
- R9: Status group A (indices 0..14) reads at word 2, group B (indices 15..28) at word 3 and group C (indices 29..45) at word 4. Each group is right-aligned from bit 0 in increasing index order, and unused bits read as 0. Other word addresses read 0.
- R10: A bus write attempt (`bus_wr_valid` with `bus_wr_id`) aimed at an identifier whose protect bit is set gives `acc_err_o` high for exactly one cycle, starting on the next rising edge. An attempt aimed at an unprotected or unmapped identifier gives no pulse.
- R11: A synchronous reset clears all protect bits, all lock bits, the error flag and the command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 24 | Register write data (implemented bits only) |
| cfg_rdata | output | 32 | Registered read data |
| bus_wr_valid | input | 1 | A bus write attempt to a peripheral is present |
| bus_wr_id | input | 16 | Identifier of the peripheral being written |
| acc_err_o | output | 1 | One-cycle pulse for a blocked write attempt |
| err_o | output | 1 | Sticky command-refused flag |
| prot_o | output | 46 | Protect bit of every mapped index |

## Verification
The bench sweeps every identifier from 0 to 63 under set, no-op, clear and invalid keys. This catches a design that maps identifiers off by one, gives the unimplemented identifiers 16 and 17 a bit, or flags the bitless identifiers as errors. The shared identifiers 1 and 2 are driven against each other, so a design that gives them separate bits leaves a stale bit set. Locked bits are hit with set and clear commands, which exposes a design that lets a lock leak or that raises an error on a repeated lock. A design that applies commands a cycle early is caught by sampling one cycle before the effect is due. The access-error pulse is checked for every identifier, both for its presence and for its one-cycle width, so a stretched or misrouted pulse shows up.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int ID_W   = 16;
  localparam int KEY_W  = 8;
  localparam int CMD_W  = KEY_W + ID_W;
  localparam int NPROT  = 46;
  localparam int IDX_W  = $clog2(NPROT);
  localparam int A_BASE = 0;
  localparam int A_W    = 15;
  localparam int B_BASE = 15;
  localparam int B_W    = 14;
  localparam int C_BASE = 29;
  localparam int C_W    = 17;
  localparam int MAX_ID = 57;

  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_CLR = 2'd1, OP_SET = 2'd2, OP_LOCK = 2'd3} op_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } map_t;

  // Translate a peripheral identifier into a protect-bit index.
  function automatic map_t id_map(input logic [ID_W-1:0] id);
    map_t m;
    int   v;
    v = int'(id);
    m.hit = 1'b1;
    m.idx = '0;
    if (v == 0)                    m.idx = IDX_W'(0);
    else if (v <= 2)               m.idx = IDX_W'(1);
    else if (v <= 15)              m.idx = IDX_W'(v - 1);
    else if (v >= 20 && v <= 22)   m.idx = IDX_W'(v - 5);
    else if (v >= 25 && v <= 35)   m.idx = IDX_W'(v - 7);
    else if (v >= 36 && v <= 50)   m.idx = IDX_W'(v - 7);
    else if (v == 54)              m.idx = IDX_W'(44);
    else if (v == 57)              m.idx = IDX_W'(45);
    else                           m.hit = 1'b0;
    return m;
  endfunction

  function automatic logic id_known(input logic [ID_W-1:0] id);
    return (int'(id) <= MAX_ID) && (id != ID_W'(16)) && (id != ID_W'(17));
  endfunction
endpackage

// File: rtl/wprot_cmd_dec.sv
module wprot_cmd_dec
  import wprot_pkg::*;
#(
  parameter int P_NPROT = NPROT,
  parameter int P_IDX_W = IDX_W
) (
  input  logic                apply,
  input  logic [KEY_W-1:0]    key,
  input  logic [ID_W-1:0]     id,
  input  logic [P_NPROT-1:0]  lock_vec,
  output logic                upd_en,
  output logic [P_IDX_W-1:0]  upd_idx,
  output op_e                 upd_op,
  output logic                cmd_err
);
  map_t m;
  logic key_ok, known, locked, soft_op;

  always_comb begin
    m       = id_map(id);
    key_ok  = (key <= KEY_W'(3));
    known   = id_known(id);
    locked  = m.hit && lock_vec[m.idx];
    soft_op = (key == KEY_W'(1)) || (key == KEY_W'(2));
    upd_op  = op_e'(key[1:0]);
    upd_idx = P_IDX_W'(m.idx);
    cmd_err = apply && (!key_ok || !known || (locked && soft_op));
    upd_en  = apply && key_ok && known && m.hit && (key != '0) && !(locked && soft_op);
  end
endmodule

// File: rtl/wprot_state.sv
module wprot_state
  import wprot_pkg::*;
#(
  parameter int P_NPROT = NPROT,
  parameter int P_IDX_W = IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_en,
  input  logic [P_IDX_W-1:0] upd_idx,
  input  op_e                upd_op,
  output logic [P_NPROT-1:0] prot_q,
  output logic [P_NPROT-1:0] lock_q
);
  for (genvar i = 0; i < P_NPROT; i++) begin : g_bit
    logic sel;
    assign sel = upd_en && (upd_idx == P_IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        prot_q[i] <= 1'b0;
        lock_q[i] <= 1'b0;
      end else if (sel) begin
        case (upd_op)
          OP_CLR:  prot_q[i] <= 1'b0;
          OP_SET:  prot_q[i] <= 1'b1;
          OP_LOCK: begin
            prot_q[i] <= 1'b1;
            lock_q[i] <= 1'b1;
          end
          default: ;
        endcase
      end
    end

    // R3: a locked bit stays locked and protected until reset
    assert_lock_holds_R3: assert property (@(posedge clk) disable iff (rst)
      lock_q[i] |=> (lock_q[i] && prot_q[i]));
  end

  // R2: protect bits move only when an update is issued
  assert_no_stray_update_R2: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(prot_q));
endmodule

// File: rtl/wprot_acc_chk.sv
module wprot_acc_chk
  import wprot_pkg::*;
#(
  parameter int P_NPROT = NPROT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [ID_W-1:0]    wr_id,
  input  logic [P_NPROT-1:0] prot,
  output logic               acc_err
);
  map_t m;
  always_comb m = id_map(wr_id);

  always_ff @(posedge clk) begin
    if (rst) acc_err <= 1'b0;
    else     acc_err <= wr_valid && m.hit && prot[m.idx];
  end

  // R10: a pulse always follows a write attempt one cycle earlier
  assert_pulse_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> $past(wr_valid));
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_re,
  input  logic [2:0]       cfg_addr,
  input  logic [CMD_W-1:0] cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             bus_wr_valid,
  input  logic [ID_W-1:0]  bus_wr_id,
  output logic             acc_err_o,
  output logic             err_o,
  output logic [NPROT-1:0] prot_o
);
  localparam logic [2:0] W_CMD = 3'd0;
  localparam logic [2:0] W_ERR = 3'd1;
  localparam logic [2:0] W_GA  = 3'd2;
  localparam logic [2:0] W_GB  = 3'd3;
  localparam logic [2:0] W_GC  = 3'd4;

  logic [CMD_W-1:0] cmd_q;
  logic             apply_q;
  logic             err_q;
  logic [NPROT-1:0] prot_q, lock_q;
  logic             upd_en, cmd_err;
  logic [IDX_W-1:0] upd_idx;
  op_e              upd_op;
  logic             err_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      apply_q <= 1'b0;
    end else begin
      apply_q <= cfg_we && (cfg_addr == W_CMD);
      if (cfg_we && (cfg_addr == W_CMD)) cmd_q <= cfg_wdata;
    end
  end

  wprot_cmd_dec #(.P_NPROT(NPROT), .P_IDX_W(IDX_W)) dec_i (
    .apply    (apply_q),
    .key      (cmd_q[CMD_W-1:ID_W]),
    .id       (cmd_q[ID_W-1:0]),
    .lock_vec (lock_q),
    .upd_en   (upd_en),
    .upd_idx  (upd_idx),
    .upd_op   (upd_op),
    .cmd_err  (cmd_err)
  );

  wprot_state #(.P_NPROT(NPROT), .P_IDX_W(IDX_W)) state_i (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .upd_idx (upd_idx),
    .upd_op  (upd_op),
    .prot_q  (prot_q),
    .lock_q  (lock_q)
  );

  wprot_acc_chk #(.P_NPROT(NPROT)) acc_i (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (bus_wr_valid),
    .wr_id    (bus_wr_id),
    .prot     (prot_q),
    .acc_err  (acc_err_o)
  );

  assign err_clr = cfg_we && (cfg_addr == W_ERR) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (cmd_err) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else if (cfg_re) begin
      case (cfg_addr)
        W_CMD:   cfg_rdata <= 32'(cmd_q);
        W_ERR:   cfg_rdata <= 32'(err_q);
        W_GA:    cfg_rdata <= 32'(prot_q[A_BASE +: A_W]);
        W_GB:    cfg_rdata <= 32'(prot_q[B_BASE +: B_W]);
        W_GC:    cfg_rdata <= 32'(prot_q[C_BASE +: C_W]);
        default: cfg_rdata <= '0;
      endcase
    end
  end

  assign err_o  = err_q;
  assign prot_o = prot_q;

  // R7: the error flag only drops through a clear write
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);

  // R7: a refused command changes no protect bit
  assert_refused_no_change_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> $stable(prot_q) && $stable(lock_q));
endmodule

// File: tb/wprot_ctrl_tb.sv
`timescale 1ns/1ps
module wprot_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_wr_valid = 1'b0;
  logic [15:0] bus_wr_id = '0;
  logic        acc_err_o, err_o;
  logic [45:0] prot_o;

  always #2 clk = ~clk;

  wprot_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_wr_valid(bus_wr_valid),
    .bus_wr_id(bus_wr_id), .acc_err_o(acc_err_o), .err_o(err_o), .prot_o(prot_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [45:0] m_prot = '0, m_lock = '0;
  logic        m_err = 1'b0;

  function automatic int ex_idx(input int id);
    if (id == 0) return 0;
    if (id == 1 || id == 2) return 1;
    if (id >= 3 && id <= 15) return id - 1;
    if (id >= 20 && id <= 22) return 15 + (id - 20);
    if (id >= 25 && id <= 35) return 18 + (id - 25);
    if (id >= 36 && id <= 50) return 29 + (id - 36);
    if (id == 54) return 44;
    if (id == 57) return 45;
    return -1;
  endfunction

  function automatic bit ex_known(input int id);
    return (id >= 0 && id <= 57 && id != 16 && id != 17);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_re = 1'b0; d = cfg_rdata;
  endtask

  task automatic model_cmd(input int key, input int id);
    int ix;
    ix = ex_idx(id);
    if (key > 3 || !ex_known(id)) m_err = 1'b1;
    else if (ix >= 0) begin
      case (key)
        1: if (m_lock[ix]) m_err = 1'b1; else m_prot[ix] = 1'b0;
        2: if (m_lock[ix]) m_err = 1'b1; else m_prot[ix] = 1'b1;
        3: begin m_prot[ix] = 1'b1; m_lock[ix] = 1'b1; end
        default: ;
      endcase
    end
  endtask

  task automatic cmd_chk(input int key, input int id, input string req);
    model_cmd(key, id);
    bus_wr(3'd0, {8'(key), 16'(id)});
    @(negedge clk);
    chk(req, $sformatf("prot key=%0d id=%0d", key, id), 64'(prot_o), 64'(m_prot));
    chk(req, $sformatf("err key=%0d id=%0d", key, id), 64'(err_o), 64'(m_err));
    if (m_err) begin
      bus_wr(3'd1, 24'd1);
      m_err = 1'b0;
      chk("R8", "err after clear", 64'(err_o), 64'd0);
    end
  endtask

  task automatic acc_try(input int id, input string req);
    int ix;
    logic e;
    ix = ex_idx(id);
    e = (ix >= 0) ? m_prot[ix] : 1'b0;
    @(negedge clk); bus_wr_valid = 1'b1; bus_wr_id = 16'(id);
    @(negedge clk); bus_wr_valid = 1'b0;
    chk(req, $sformatf("acc pulse id=%0d", id), 64'(acc_err_o), 64'(e));
    @(negedge clk);
    chk(req, $sformatf("acc pulse end id=%0d", id), 64'(acc_err_o), 64'd0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_prot = '0; m_lock = '0; m_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 / R1: state after reset
    chk("R11", "prot after reset", 64'(prot_o), 64'd0);
    chk("R11", "err after reset", 64'(err_o), 64'd0);
    chk("R11", "acc after reset", 64'(acc_err_o), 64'd0);
    bus_rd(3'd0, rd);
    chk("R1", "cmd readback after reset", 64'(rd), 64'd0);

    // R2: effect timing
    bus_wr(3'd0, {8'd2, 16'd0});
    chk("R2", "prot not yet applied", 64'(prot_o[0]), 64'd0);
    @(negedge clk);
    chk("R2", "prot applied", 64'(prot_o[0]), 64'd1);
    m_prot[0] = 1'b1;
    cmd_chk(1, 0, "R2");

    // R4 R6 R7: sweep all identifiers with set, no-op, clear, bad key
    for (int id = 0; id < 64; id++) begin
      cmd_chk(2, id, "R4");
      cmd_chk(0, id, "R2");
      cmd_chk(1, id, "R4");
      cmd_chk(5, id, "R7");
    end
    // R6: lock on bitless identifiers is a silent no-op
    cmd_chk(3, 18, "R6");
    cmd_chk(3, 56, "R6");

    // R1: readback masks to 24 bits
    model_cmd(255, 16'hABCD);
    bus_wr(3'd0, 24'hFFABCD);
    bus_rd(3'd0, rd);
    chk("R1", "cmd readback", 64'(rd), 64'h00FFABCD);

    // R8: writing 0 leaves the flag, writing 1 clears it
    chk("R8", "err set", 64'(err_o), 64'd1);
    bus_wr(3'd1, 24'd0);
    chk("R8", "err after write 0", 64'(err_o), 64'd1);
    bus_rd(3'd1, rd);
    chk("R8", "err readback", 64'(rd), 64'd1);
    bus_wr(3'd1, 24'd1);
    m_err = 1'b0;
    chk("R8", "err after write 1", 64'(err_o), 64'd0);

    // R5: shared identifiers act on one bit
    cmd_chk(2, 1, "R5");
    chk("R5", "shared bit set", 64'(prot_o[1]), 64'd1);
    cmd_chk(1, 2, "R5");
    chk("R5", "shared bit cleared via other id", 64'(prot_o[1]), 64'd0);

    // R9: status groups
    cmd_chk(2, 0, "R9");  cmd_chk(2, 15, "R9");
    cmd_chk(2, 20, "R9"); cmd_chk(2, 35, "R9");
    cmd_chk(2, 36, "R9"); cmd_chk(2, 57, "R9");
    bus_rd(3'd2, rd); chk("R9", "group A", 64'(rd), 64'h4001);
    bus_rd(3'd3, rd); chk("R9", "group B", 64'(rd), 64'h2001);
    bus_rd(3'd4, rd); chk("R9", "group C", 64'(rd), 64'h10001);
    bus_rd(3'd5, rd); chk("R9", "unused word", 64'(rd), 64'd0);

    // R10: access error for every identifier
    for (int id = 0; id < 64; id++) acc_try(id, "R10");

    // R3: lock behaviour
    cmd_chk(3, 2, "R3");
    cmd_chk(3, 30, "R3");
    cmd_chk(1, 1, "R3");
    cmd_chk(2, 2, "R3");
    cmd_chk(1, 30, "R3");
    cmd_chk(3, 1, "R3");
    cmd_chk(0, 30, "R3");
    chk("R3", "locked bit 1 held", 64'(prot_o[1]), 64'd1);
    chk("R3", "locked bit 23 held", 64'(prot_o[23]), 64'd1);
    acc_try(2, "R10");

    // R11: reset releases locks
    do_reset();
    @(negedge clk);
    chk("R11", "prot after second reset", 64'(prot_o), 64'd0);
    chk("R11", "err after second reset", 64'(err_o), 64'd0);
    bus_rd(3'd0, rd);
    chk("R11", "cmd after second reset", 64'(rd), 64'd0);
    cmd_chk(2, 2, "R11");
    cmd_chk(1, 2, "R11");
    chk("R11", "lock released", 64'(prot_o[1]), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule